// File: doc/BRIEF.md
# Standby Clock-Gating Controller

This block decides which clocks of a processing core may run while the core waits in standby. When the core executes its idle instruction, it raises a one-cycle strobe. The controller then samples three configuration bits and picks one of four standby modes. Each mode turns off a different set of enables among the core clock enable, the peripheral clock enable and the PLL enable.

An interrupt request wakes the block from any mode. If the PLL was stopped, the controller first lets the PLL run for a programmable lock count while the clocks stay off. It then turns the clocks back on and waits a fixed two cycles. At that point it sends a one-cycle resume strobe so the core can continue after the idle instruction. In modes that drop the pipeline contents, a flush pulse goes out together with the resume strobe.

All enables come straight from flip-flops clocked on the rising edge. An external latch-based gate cell can therefore take them while the gated clock is low, and no glitch reaches the gated clock.

Top module: `lowPowerCtrl`

## Requirements
- R1: At the idle strobe the mode is chosen with this priority. `cfgStopAll`=1 selects Full-Stop. Otherwise `cfgPdwn`=1 selects Core+Peripheral-Stop. Otherwise `cfgStopClk`=1 selects Core-Stop. With all three bits 0 the mode is Plain-Idle.
- R2: A mode is entered only by `idleStb` while `coreRun` is 1. `coreRun` reads 0 from the cycle after that edge. Changes of `idleStb` and of the configuration bits while asleep have no effect on any output.
- R3: In Plain-Idle all three enables stay 1.
- R4: In Core-Stop `coreClkEn` is 0, while `periClkEn` and `pllEn` stay 1.
- R5: In Core+Peripheral-Stop `coreClkEn` and `periClkEn` are 0, while `pllEn` stays 1.
- R6: In Full-Stop all three enables are 0.
- R7: Outside Full-Stop, suppose `irqReq` is sampled at edge e while asleep. The clock enables are all 1 after edge e. `resumeStb` is 1 for exactly the one cycle after edge e+2, and `coreRun` is 1 from that cycle on.
- R8: In Full-Stop, suppose `irqReq` is sampled at edge e. `pllEn` is 1 after edge e. The core and peripheral enables stay 0 until edge e+L+1, with L = `lockCount` sampled at edge e. They are 1 from then on, and `resumeStb` pulses after edge e+L+3.
- R9: `pipeFlush` pulses together with `resumeStb` on wake-up from Core+Peripheral-Stop or Full-Stop. It never pulses on wake-up from Plain-Idle or Core-Stop.
- R10: `irqReq` while running has no effect on any output.
- R11: Every output is a register output that changes only after a rising clock edge. Input changes between edges never show up before the next edge.
- R12: Reset sets all enables to 1, sets `coreRun` to 1, and sets `resumeStb` and `pipeFlush` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleStb | input | 1 | Idle instruction executed (one-cycle strobe) |
| cfgPdwn | input | 1 | Power-down configuration bit |
| cfgStopClk | input | 1 | Stop-clock configuration bit |
| cfgStopAll | input | 1 | Stop-all configuration bit |
| irqReq | input | 1 | Wake-up interrupt request |
| lockCount | input | LOCK_W | PLL lock wait in cycles, used on wake-up from Full-Stop |
| coreClkEn | output | 1 | Core clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| pllEn | output | 1 | PLL enable |
| pipeFlush | output | 1 | One-cycle pipeline flush pulse |
| resumeStb | output | 1 | One-cycle resume strobe |
| coreRun | output | 1 | 1 while the core executes |

## Verification
The hardest situation to reach is a Full-Stop wake-up. There, the enables depend on a lock count captured at the interrupt edge, followed by the fixed resume latency. An early or late enable by one cycle is easy to miss. The bench sweeps all eight configuration codes against several lock counts, including zero. It compares every output in every cycle from the interrupt to one cycle past the resume, against indices it computes from L. While asleep, it also toggles the idle strobe and flips the configuration bits to show that the chosen mode stays in place.

// File: rtl/lpcPkg.sv
package lpcPkg;
  typedef enum logic [1:0] {MODE_IDLE, MODE_CORE, MODE_COREPERI, MODE_ALL} lpMode_e;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_LOCK, ST_WAKE} lpState_e;

  typedef struct packed {
    logic latchMode;
    logic armLock;
    logic armWake;
    logic countDown;
    logic finish;
  } lpStb_t;

  function automatic lpMode_e decodeMode(input logic pdwn, input logic stopClk,
                                         input logic stopAll);
    if (stopAll)      return MODE_ALL;
    else if (pdwn)    return MODE_COREPERI;
    else if (stopClk) return MODE_CORE;
    else              return MODE_IDLE;
  endfunction
endpackage

// File: rtl/lpcCtrl.sv
module lpcCtrl
  import lpcPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   idleStb,
  input  logic   irqReq,
  input  logic   modeIsAll,
  input  logic   cntZero,
  output lpStb_t stb
);
  lpState_e state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_RUN: if (idleStb) begin
        stb.latchMode = 1'b1;
        stateNext     = ST_SLEEP;
      end
      ST_SLEEP: if (irqReq) begin
        if (modeIsAll) begin
          stb.armLock = 1'b1;
          stateNext   = ST_LOCK;
        end else begin
          stb.armWake = 1'b1;
          stateNext   = ST_WAKE;
        end
      end
      ST_LOCK: if (cntZero) begin
        stb.armWake = 1'b1;
        stateNext   = ST_WAKE;
      end else begin
        stb.countDown = 1'b1;
      end
      ST_WAKE: if (cntZero) begin
        stb.finish = 1'b1;
        stateNext  = ST_RUN;
      end else begin
        stb.countDown = 1'b1;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end
endmodule

// File: rtl/lpcDatapath.sv
module lpcDatapath
  import lpcPkg::*;
#(
  parameter int LOCK_W     = 8,
  parameter int RESUME_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpStb_t            stb,
  input  logic              cfgPdwn,
  input  logic              cfgStopClk,
  input  logic              cfgStopAll,
  input  logic [LOCK_W-1:0] lockCount,
  output logic              modeIsAll,
  output logic              cntZero,
  output logic              coreClkEn,
  output logic              periClkEn,
  output logic              pllEn,
  output logic              pipeFlush,
  output logic              resumeStb,
  output logic              coreRun
);
  localparam logic [LOCK_W-1:0] WAKE_LOAD = LOCK_W'(RESUME_LAT - 1);

  lpMode_e           mode;
  lpMode_e           modeNew;
  logic [LOCK_W-1:0] cnt;
  logic              keepsPipe;

  assign modeNew   = decodeMode(cfgPdwn, cfgStopClk, cfgStopAll);
  assign modeIsAll = (mode == MODE_ALL);
  assign cntZero   = (cnt == '0);
  assign keepsPipe = (mode == MODE_IDLE) || (mode == MODE_CORE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode      <= MODE_IDLE;
      cnt       <= '0;
      coreClkEn <= 1'b1;
      periClkEn <= 1'b1;
      pllEn     <= 1'b1;
      pipeFlush <= 1'b0;
      resumeStb <= 1'b0;
      coreRun   <= 1'b1;
    end else begin
      pipeFlush <= 1'b0;
      resumeStb <= 1'b0;
      if (stb.latchMode) begin
        mode      <= modeNew;
        coreClkEn <= (modeNew == MODE_IDLE);
        periClkEn <= (modeNew == MODE_IDLE) || (modeNew == MODE_CORE);
        pllEn     <= (modeNew != MODE_ALL);
        coreRun   <= 1'b0;
      end
      if (stb.armLock) begin
        cnt   <= lockCount;
        pllEn <= 1'b1;
      end
      if (stb.armWake) begin
        cnt       <= WAKE_LOAD;
        coreClkEn <= 1'b1;
        periClkEn <= 1'b1;
        pllEn     <= 1'b1;
      end
      if (stb.countDown) cnt <= cnt - 1'b1;
      if (stb.finish) begin
        coreRun   <= 1'b1;
        resumeStb <= 1'b1;
        pipeFlush <= !keepsPipe;
      end
    end
  end
endmodule

// File: rtl/lowPowerCtrl.sv
module lowPowerCtrl
  import lpcPkg::*;
#(
  parameter int LOCK_W     = 8,
  parameter int RESUME_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idleStb,
  input  logic              cfgPdwn,
  input  logic              cfgStopClk,
  input  logic              cfgStopAll,
  input  logic              irqReq,
  input  logic [LOCK_W-1:0] lockCount,
  output logic              coreClkEn,
  output logic              periClkEn,
  output logic              pllEn,
  output logic              pipeFlush,
  output logic              resumeStb,
  output logic              coreRun
);
  lpStb_t stb;
  logic   modeIsAll;
  logic   cntZero;

  lpcCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .idleStb(idleStb), .irqReq(irqReq),
    .modeIsAll(modeIsAll), .cntZero(cntZero), .stb(stb)
  );

  lpcDatapath #(.LOCK_W(LOCK_W), .RESUME_LAT(RESUME_LAT)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgPdwn(cfgPdwn), .cfgStopClk(cfgStopClk), .cfgStopAll(cfgStopAll),
    .lockCount(lockCount), .modeIsAll(modeIsAll), .cntZero(cntZero),
    .coreClkEn(coreClkEn), .periClkEn(periClkEn), .pllEn(pllEn),
    .pipeFlush(pipeFlush), .resumeStb(resumeStb), .coreRun(coreRun)
  );
endmodule

// File: rtl/lowPowerCtrlChk.sv
module lowPowerCtrlChk (
  input logic clk,
  input logic rstN,
  input logic idleStb,
  input logic irqReq,
  input logic coreClkEn,
  input logic periClkEn,
  input logic pllEn,
  input logic pipeFlush,
  input logic resumeStb,
  input logic coreRun
);
  AST_PLL_OFF_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !pllEn |-> (!coreClkEn && !periClkEn)); // R6
  AST_PERI_OFF_CORE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !periClkEn |-> !coreClkEn); // R5
  AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rstN)
    coreRun |-> (coreClkEn && periClkEn && pllEn)); // R7
  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resumeStb |=> !resumeStb); // R7
  AST_FLUSH_WITH_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    pipeFlush |-> resumeStb); // R9
  AST_SLEEP_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreRun) |-> $past(idleStb)); // R2
  AST_PLL_WAKE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllEn) |-> $past(irqReq)); // R8
endmodule

bind lowPowerCtrl lowPowerCtrlChk i_lowPowerCtrlChk (
  .clk(clk), .rstN(rstN), .idleStb(idleStb), .irqReq(irqReq),
  .coreClkEn(coreClkEn), .periClkEn(periClkEn), .pllEn(pllEn),
  .pipeFlush(pipeFlush), .resumeStb(resumeStb), .coreRun(coreRun)
);

// File: tb/test_lowPowerCtrl.sv
`timescale 1ns/1ps
module test_lowPowerCtrl;
  localparam int LOCK_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idleStb = 1'b0, cfgPdwn = 1'b0, cfgStopClk = 1'b0, cfgStopAll = 1'b0;
  logic irqReq = 1'b0;
  logic [LOCK_W-1:0] lockCount = '0;
  logic coreClkEn, periClkEn, pllEn, pipeFlush, resumeStb, coreRun;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lowPowerCtrl #(.LOCK_W(LOCK_W)) i_lowPowerCtrl (
    .clk(clk), .rstN(rstN), .idleStb(idleStb), .cfgPdwn(cfgPdwn),
    .cfgStopClk(cfgStopClk), .cfgStopAll(cfgStopAll), .irqReq(irqReq),
    .lockCount(lockCount), .coreClkEn(coreClkEn), .periClkEn(periClkEn),
    .pllEn(pllEn), .pipeFlush(pipeFlush), .resumeStb(resumeStb), .coreRun(coreRun)
  );

  // packed view of outputs: {core, peri, pll, flush, resume, run}
  function automatic logic [5:0] outs();
    return {coreClkEn, periClkEn, pllEn, pipeFlush, resumeStb, coreRun};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // 0 Plain-Idle, 1 Core-Stop, 2 Core+Peripheral-Stop, 3 Full-Stop
  function automatic int refMode(input logic pd, input logic sc, input logic sa);
    if (sa) return 3;
    if (pd) return 2;
    if (sc) return 1;
    return 0;
  endfunction

  function automatic logic [5:0] sleepOuts(input int m);
    return {m == 0, m <= 1, m != 3, 1'b0, 1'b0, 1'b0};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset", outs(), 6'b111001);
    rstN = 1'b1;
    @(negedge clk);
    check("R12 after reset", outs(), 6'b111001);

    // R10: interrupt while running is ignored
    irqReq = 1'b1;
    @(negedge clk);
    irqReq = 1'b0;
    check("R10 irq while running", outs(), 6'b111001);
    @(negedge clk);
    check("R10 irq while running later", outs(), 6'b111001);

    for (int lc = 0; lc < 3; lc++) begin
      for (int code = 0; code < 8; code++) begin
        int m, L, enIdx, resIdx;
        logic [5:0] exp;
        L = (lc == 0) ? 0 : (lc == 1) ? 1 : 4;
        m = refMode(code[0], code[1], code[2]);
        cfgPdwn = code[0]; cfgStopClk = code[1]; cfgStopAll = code[2];
        idleStb = 1'b1;
        #1;
        check("R11 no change before edge", outs(), 6'b111001);
        @(negedge clk);
        idleStb = 1'b0;
        check($sformatf("R1 R2 R3 R4 R5 R6 enter mode %0d", m), outs(), sleepOuts(m));
        // R2: idle strobe and config changes while asleep are ignored
        cfgPdwn = ~code[0]; cfgStopClk = ~code[1]; cfgStopAll = ~code[2];
        idleStb = 1'b1;
        @(negedge clk);
        idleStb = 1'b0;
        check("R2 idle while asleep ignored", outs(), sleepOuts(m));
        repeat (2) @(negedge clk);
        check("R2 mode held", outs(), sleepOuts(m));
        // wake-up
        lockCount = LOCK_W'(L);
        irqReq = 1'b1;
        @(negedge clk);
        irqReq = 1'b0;
        lockCount = 8'hFF;
        enIdx = (m == 3) ? L + 1 : 0;
        resIdx = enIdx + 2;
        for (int k = 0; k <= resIdx + 1; k++) begin
          exp[5] = (k >= enIdx) || (m == 0);
          exp[4] = (k >= enIdx) || (m <= 1);
          exp[3] = 1'b1;
          exp[2] = (k == resIdx) && (m >= 2);
          exp[1] = (k == resIdx);
          exp[0] = (k >= resIdx);
          check($sformatf("%s mode %0d L %0d k %0d",
                (m == 3) ? "R8 R9" : "R7 R9", m, L, k), outs(), exp);
          @(negedge clk);
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule